// File: doc/BRIEF.md
# Block-Write Control Register Slave

This block is a two-wire serial slave that holds a small bank of 8-bit control registers for a clock generator. It watches the bus clock and data lines and, when its own 7-bit address is seen, takes a block transfer. Each write begins with two placeholder bytes: a command byte and a count byte. The slave acknowledges both and throws their contents away. The data bytes that follow land in register 0, register 1, register 2 and onward, one after the other. A read returns the bank in the same order, again starting from register 0. No access can pick a single register by its offset.

The bank drives the chip directly through a flat parallel output. It holds clock-stop enables (1 = clock running, 0 = clock stopped), the spread-spectrum controls, strap status bits that come from outside, a timeout status flag, and two fixed identification bytes. The slave pulls SDA low through an open-drain enable. It never holds SCL low.

Top module: `i2c_blockreg_slave`

## Requirements
- R1: After reset the bank reads as follows: reg0 0x00, reg1 0xCF, reg2 0xFF, reg3 0xFF, reg4 {strap_i,3'b111}, reg5 0x93, reg6 0x00, reg7 0x20, reg8 to reg10 0x00, reg11 0x62, reg12 0x41. The all-ones bytes in reg2 and reg3 are clock enables, with 1 meaning running.
- R2: The slave answers only address 0x69. Answering means driving SDA low during the ninth bit. Any other address gets no answer, and the bytes sent after it change no register.
- R3: After a write address, the first two bytes (command and count) are acknowledged and change no register.
- R4: After those two bytes, each data byte is acknowledged and stored in the next register, starting at reg0. Register contents change only on an SCL falling edge.
- R5: Some fields are read-only and writes to them are ignored: reg4 bits 7:3 always show strap_i, reg6 bit 6 always shows wd_flag_i, and reg11 and reg12 always read 0x62 and 0x41.
- R6: The spread-spectrum controls come from reg1: ssc_center is bit 6 (1 = centre spread, 0 = down spread), ssc_en is bit 5, and ssc_wide is bit 4 (1 = 0.5 %, 0 = 0.25 %).
- R7: A read address is acknowledged. The slave then sends reg0, reg1 and so on, MSB first.
- R8: Data bytes written after reg12 are acknowledged and discarded. Bytes read after reg12 return 0xFF.
- R9: When the master NACKs a read byte, the slave releases SDA and the read ends. The next transfer starts again at reg0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | When 1, pull the SDA line low |
| strap_i | input | 5 | Strap status, shown in reg4 bits 7:3 |
| wd_flag_i | input | 1 | Timeout status, shown in reg6 bit 6 |
| regs_o | output | 104 | Register bank; register k is at bits 8k+7:8k |
| ssc_center | output | 1 | Centre (1) or down (0) spread |
| ssc_en | output | 1 | Spread spectrum enable |
| ssc_wide | output | 1 | Modulation depth 0.5 % (1) or 0.25 % (0) |

## Verification
Two functions can act in the same cycle: a read-only field is refreshed from its input while a bus write lands on that same register. In the vector loop, writes of all-ones and all-zeros go to reg4, reg6, reg11 and reg12. Each result is judged on regs_o, where the writable bits must show the new byte and the read-only bits must still show the strap, the flag or the identification value. A second overlap comes at the end of the bank: the pointer reaches its end just as extra bytes keep arriving. Overlong writes and reads test this, and the bench checks both the acknowledge and the 0xFF filler.

// File: rtl/i2c_blockreg_slave.sv
module i2c_blockreg_slave #(
  parameter logic [6:0] DEV_ADDR = 7'h69,
  parameter int NREG = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic [4:0]        strap_i,
  input  logic              wd_flag_i,
  output logic [NREG*8-1:0] regs_o,
  output logic              ssc_center,
  output logic              ssc_en,
  output logic              ssc_wide
);
  localparam int PW = $clog2(NREG + 1);
  localparam logic [2:0] S_IDLE = 3'd0, S_ADDR = 3'd1, S_WR = 3'd2, S_ACK = 3'd3,
                         S_RD = 3'd4, S_MACK = 3'd5, S_MLD = 3'd6;

  function automatic logic [7:0] dflt(int i);
    case (i)
      1:       return 8'hCF;
      2, 3:    return 8'hFF;
      4:       return 8'h07;
      5:       return 8'h93;
      7:       return 8'h20;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] wmask(int i);
    case (i)
      4:       return 8'h07;
      6:       return 8'hBF;
      11, 12:  return 8'h00;
      default: return 8'hFF;
    endcase
  endfunction

  logic [2:0]    scl_s, sda_s, st;
  logic [7:0]    sh, rbyte;
  logic [3:0]    bitc;
  logic [1:0]    widx;
  logic          rw;
  logic [PW-1:0] ptr;
  logic [7:0]    rf   [NREG];
  logic [7:0]    view [NREG];

  wire scl_rise = scl_s[1] & ~scl_s[2];
  wire scl_fall = ~scl_s[1] & scl_s[2];
  wire start    = scl_s[1] & scl_s[2] & sda_s[2] & ~sda_s[1];
  wire stop     = scl_s[1] & scl_s[2] & ~sda_s[2] & sda_s[1];

  for (genvar g = 0; g < NREG; g++) begin : g_view
    localparam logic [7:0] WM = wmask(g);
    logic [7:0] rov;
    assign rov = (g == 4)  ? {strap_i, 3'b000} :
                 (g == 6)  ? {1'b0, wd_flag_i, 6'b0} :
                 (g == 11) ? 8'h62 :
                 (g == 12) ? 8'h41 : 8'h00;
    assign view[g] = (rf[g] & WM) | (rov & ~WM);
    assign regs_o[g*8 +: 8] = view[g];
  end

  assign ssc_center = view[1][6];
  assign ssc_en     = view[1][5];
  assign ssc_wide   = view[1][4];

  always_comb begin
    rbyte = 8'hFF;
    for (int i = 0; i < NREG; i++)
      if (ptr == PW'(i)) rbyte = view[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_s <= 3'b111; sda_s <= 3'b111; st <= S_IDLE; sh <= '0; bitc <= '0;
      widx <= '0; rw <= 1'b0; ptr <= '0; sda_oe <= 1'b0;
      for (int i = 0; i < NREG; i++) rf[i] <= dflt(i);
    end else begin
      scl_s <= {scl_s[1:0], scl_i};
      sda_s <= {sda_s[1:0], sda_i};
      if (start) begin
        st <= S_ADDR; bitc <= '0; widx <= '0; ptr <= '0; sda_oe <= 1'b0;
      end else if (stop) begin
        st <= S_IDLE; sda_oe <= 1'b0;
      end else begin
        case (st)
          S_ADDR, S_WR:
            if (scl_rise) begin
              sh <= {sh[6:0], sda_s[1]};
              bitc <= bitc + 4'd1;
            end else if (scl_fall && bitc == 4'd8) begin
              bitc <= '0;
              if (st == S_ADDR) begin
                if (sh[7:1] == DEV_ADDR) begin
                  rw <= sh[0]; sda_oe <= 1'b1; st <= S_ACK;
                end else st <= S_IDLE;
              end else begin
                sda_oe <= 1'b1; st <= S_ACK;
                if (widx != 2'd2) widx <= widx + 2'd1;
                else begin
                  for (int i = 0; i < NREG; i++)
                    if (ptr == PW'(i)) rf[i] <= sh;
                  if (ptr != PW'(NREG)) ptr <= ptr + 1'b1;
                end
              end
            end
          S_ACK:
            if (scl_fall) begin
              bitc <= '0;
              if (rw) begin
                sh <= rbyte; sda_oe <= ~rbyte[7]; st <= S_RD;
              end else begin
                sda_oe <= 1'b0; st <= S_WR;
              end
            end
          S_RD:
            if (scl_fall) begin
              if (bitc == 4'd7) begin
                sda_oe <= 1'b0; st <= S_MACK;
                if (ptr != PW'(NREG)) ptr <= ptr + 1'b1;
              end else begin
                sda_oe <= ~sh[6]; sh <= {sh[6:0], 1'b0}; bitc <= bitc + 4'd1;
              end
            end
          S_MACK:
            if (scl_rise) st <= sda_s[1] ? S_IDLE : S_MLD;
          S_MLD:
            if (scl_fall) begin
              sh <= rbyte; sda_oe <= ~rbyte[7]; bitc <= '0; st <= S_RD;
            end
          default: st <= S_IDLE;
        endcase
      end
    end
  end
endmodule

module i2c_blockreg_chk #(
  parameter int NREG = 13,
  parameter int PW = $clog2(NREG + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        st,
  input logic              sda_oe,
  input logic              scl_fall,
  input logic [1:0]        widx,
  input logic [PW-1:0]     ptr,
  input logic [NREG*8-1:0] regs_o,
  input logic [4:0]        strap_i,
  input logic              wd_flag_i
);
  // R1
  rst_dflt_chk: assert property (@(posedge clk) !rst_n |=> regs_o[31:16] == 16'hFFFF);
  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st == 3'd0 |-> !sda_oe);
  // R3
  dummy_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd2 && widx != 2'd2 && $stable(strap_i) && $stable(wd_flag_i)) |=> $stable(regs_o));
  // R4
  write_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(regs_o) && $stable(strap_i) && $stable(wd_flag_i)) |-> $past(scl_fall));
  // R8
  ptr_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ptr <= PW'(NREG));
  // R9
  mack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st == 3'd5 |-> !sda_oe);
endmodule

bind i2c_blockreg_slave i2c_blockreg_chk #(.NREG(NREG)) u_chk (
  .clk(clk), .rst_n(rst_n), .st(st), .sda_oe(sda_oe), .scl_fall(scl_fall),
  .widx(widx), .ptr(ptr), .regs_o(regs_o), .strap_i(strap_i), .wd_flag_i(wd_flag_i)
);

// File: tb/i2c_blockreg_slave_bench.sv
module i2c_blockreg_slave_bench;
  localparam int NREG = 13;
  localparam int T = 10;
  localparam logic [6:0] ADDR = 7'h69;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1, sda_m = 1'b1;
  logic [4:0] strap = 5'b10110;
  logic wd = 1'b0;
  logic sda_oe, ssc_center, ssc_en, ssc_wide;
  logic [NREG*8-1:0] regs_o;
  wire sda = sda_m & ~sda_oe;

  always #2 clk = ~clk;

  i2c_blockreg_slave u_i2c_blockreg_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda), .sda_oe(sda_oe),
    .strap_i(strap), .wd_flag_i(wd), .regs_o(regs_o),
    .ssc_center(ssc_center), .ssc_en(ssc_en), .ssc_wide(ssc_wide)
  );

  int checks = 0, fails = 0;
  logic [7:0] mdl [NREG];
  logic [7:0] wbuf [16];

  // {index, written byte, expected view}
  localparam logic [23:0] VEC [9] = '{
    {8'd0, 8'h5A, 8'h5A}, {8'd1, 8'h3C, 8'h3C}, {8'd2, 8'h00, 8'h00},
    {8'd3, 8'hA5, 8'hA5}, {8'd4, 8'h00, 8'hB0}, {8'd6, 8'hFF, 8'hBF},
    {8'd11, 8'h00, 8'h62}, {8'd12, 8'hFF, 8'h41}, {8'd9, 8'h81, 8'h81}
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bstart();
    sda_m = 1'b1; scl = 1'b1; wt(T); sda_m = 1'b0; wt(T); scl = 1'b0; wt(T);
  endtask

  task automatic bstop();
    sda_m = 1'b0; wt(T); scl = 1'b1; wt(T); sda_m = 1'b1; wt(T);
  endtask

  task automatic wbit(input logic b);
    sda_m = b; wt(T); scl = 1'b1; wt(T); scl = 1'b0; wt(T);
  endtask

  task automatic rbit(output logic b);
    sda_m = 1'b1; wt(T); scl = 1'b1; wt(T / 2); b = sda; wt(T / 2); scl = 1'b0; wt(T);
  endtask

  task automatic send(input logic [7:0] v, output logic ack);
    for (int i = 7; i >= 0; i--) wbit(v[i]);
    rbit(ack);
  endtask

  task automatic recv(output logic [7:0] v, input logic nack);
    for (int i = 7; i >= 0; i--) rbit(v[i]);
    wbit(nack);
  endtask

  task automatic wr_block(input int n);
    logic a;
    bstart();
    send({ADDR, 1'b0}, a); chk("R2 address ack", {7'd0, a}, 8'd0);
    send(8'hAA, a);        chk("R3 command ack", {7'd0, a}, 8'd0);
    send(8'hBB, a);        chk("R3 count ack", {7'd0, a}, 8'd0);
    for (int i = 0; i < n; i++) begin
      send(wbuf[i], a);
      chk(i < NREG ? "R4 data ack" : "R8 overflow ack", {7'd0, a}, 8'd0);
    end
    bstop();
  endtask

  function automatic logic [7:0] rg(input int i);
    return regs_o[i*8 +: 8];
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic a;
    logic [7:0] b;
    mdl = '{8'h00, 8'hCF, 8'hFF, 8'hFF, 8'hB7, 8'h93, 8'h00, 8'h20,
            8'h00, 8'h00, 8'h00, 8'h62, 8'h41};
    wt(5); rst_n = 1'b1; wt(5);

    // R1 reset defaults, R6 decode of reg1 = 0xCF
    for (int i = 0; i < NREG; i++) chk("R1 reset value", rg(i), mdl[i]);
    chk("R6 reset spread bits", {5'd0, ssc_center, ssc_en, ssc_wide}, 8'h04);

    // R2 foreign address: no ack, no effect
    bstart();
    send({7'h50, 1'b0}, a); chk("R2 foreign address nack", {7'd0, a}, 8'd1);
    send(8'h00, a); send(8'h00, a); send(8'h11, a);
    bstop();
    for (int i = 0; i < NREG; i++) chk("R2 foreign write ignored", rg(i), mdl[i]);

    // R3 dummy bytes ignored, first data to reg0
    wbuf[0] = 8'h11; wr_block(1);
    chk("R3 first data to reg0", rg(0), 8'h11);
    chk("R3 reg1 untouched", rg(1), 8'hCF);
    mdl[0] = 8'h11;

    // R4 / R5 vector table
    for (int v = 0; v < 9; v++) begin
      int idx;
      idx = int'(VEC[v][23:16]);
      for (int i = 0; i < idx; i++) wbuf[i] = mdl[i];
      wbuf[idx] = VEC[v][15:8];
      wr_block(idx + 1);
      chk((idx == 4 || idx == 6 || idx >= 11) ? "R5 read-only field" : "R4 sequential write",
          rg(idx), VEC[v][7:0]);
      mdl[idx] = VEC[v][7:0];
    end

    // R6 spread controls
    wbuf[0] = mdl[0]; wbuf[1] = 8'h70; wr_block(2);
    chk("R6 spread all set", {5'd0, ssc_center, ssc_en, ssc_wide}, 8'h07);
    wbuf[1] = 8'h40; wr_block(2);
    chk("R6 centre only", {5'd0, ssc_center, ssc_en, ssc_wide}, 8'h04);
    mdl[1] = 8'h40;

    // R8 overlong write discarded
    for (int i = 0; i < NREG; i++) wbuf[i] = mdl[i];
    wbuf[13] = 8'h00; wbuf[14] = 8'h00;
    wr_block(15);
    for (int i = 0; i < NREG; i++) chk("R8 overflow write discarded", rg(i), mdl[i]);

    // R5 timeout flag appears in reg6 bit 6
    wd = 1'b1; wt(5);
    chk("R5 flag bit follows input", rg(6), 8'hFF);
    mdl[6] = 8'hFF;

    // R7 / R8 block read with filler
    bstart();
    send({ADDR, 1'b1}, a); chk("R7 read address ack", {7'd0, a}, 8'd0);
    for (int i = 0; i < 15; i++) begin
      recv(b, i == 14);
      if (i < NREG) chk("R7 read byte", b, mdl[i]);
      else chk("R8 read past end", b, 8'hFF);
    end
    bstop();

    // R9 early nack, next read restarts at reg0
    bstart();
    send({ADDR, 1'b1}, a);
    recv(b, 1'b0); recv(b, 1'b1);
    chk("R9 second byte before nack", b, mdl[1]);
    chk("R9 line released after nack", {7'd0, sda}, 8'd1);
    bstop();
    bstart();
    send({ADDR, 1'b1}, a);
    recv(b, 1'b1);
    chk("R9 restart at reg0", b, mdl[0]);
    bstop();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule